// File: doc/BRIEF.md
# Ethernet PHY Interrupt Status and Mask Unit

This block gathers eight event sources from an Ethernet PHY and turns them into one interrupt pin. Each source has a sticky status flag and a read/write enable bit. Both live in one 16-bit interrupt register. Enables sit in the upper byte and flags in the lower byte, in the same source order. Reading that register returns its contents and clears every flag.

Two sources are edge-qualified. The receive-error flag latches only on a rising edge of its input. The link flag latches only when the link goes from OK to not OK. The other six sources latch whenever their input is high on a clock edge.

A companion control register holds the pin polarity bit and four plain configuration bits. A simple parallel port (address, write data, write strobe, read strobe, read data) reaches both registers. The serial management framing sits outside this block.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset the interrupt register (address 17) and the control register (address 16) read 0, and `irqPin` is 1, the inactive level for active-low polarity.
- R2: Bits 15:8 of address 17 are enables and can be written. Writes to bits 7:0 of address 17 have no effect.
- R3: Six sources are level-qualified: jabber (flag bit 7), page received (bit 5), parallel detect fault (bit 4), partner acknowledge (bit 3), remote fault (bit 1) and negotiation complete (bit 0). A high input on a clock edge sets its flag.
- R4: The receive-error flag (bit 6) sets only on a low-to-high change of `evRxErr`. An input held high does not set it again after a clear.
- R5: The link flag (bit 2) sets only when `evLinkOk` falls from 1 (OK) to 0 (not OK). A rise sets nothing. After reset the previous link value is taken as 0.
- R6: A read strobe at address 17 returns the pre-clear value `{enables, flags}`. All flags are 0 afterwards unless a new event arrives.
- R7: A source that fires in the same cycle as a clearing read leaves its flag set.
- R8: A flag latches even when its enable is 0. Setting the enable later raises the interrupt at once.
- R9: `irqPin` is active whenever `flags & enables` is nonzero and inactive otherwise. Control bit 14 sets the active level: 1 means active high, 0 means active low.
- R10: In the control register only bits 14, 13, 11, 5 and 4 are read/write. All other bits read 0 and ignore writes.
- R11: Reads of address 16 leave the flags unchanged. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (clears flags at address 17) |
| rdData | output | 16 | Read data for `regAddr` |
| evJabber | input | 1 | Jabber detected |
| evRxErr | input | 1 | Raw receive error |
| evPageRx | input | 1 | New page received during negotiation |
| evPdFault | input | 1 | Parallel detect fault |
| evLpAck | input | 1 | Pulse burst with acknowledge bit received |
| evLinkOk | input | 1 | Link status, 1 = OK |
| evRemFault | input | 1 | Remote fault |
| evAnegDone | input | 1 | Auto-negotiation complete |
| irqPin | output | 1 | Interrupt output at the programmed level |

## Verification
The bench sweeps both pin polarities against all eight sources. In each run only a different source's enable is set. This shows that a masked flag still latches and holds the pin inactive, and that enabling it later raises the pin. The read values separate each source's bit position and confirm the clear-on-read behaviour. Directed runs follow:
- a held receive error, which separates edge detection from level sensing;
- a link rise against a link drop, which checks the direction of the link edge;
- a jabber event during a clearing read, which checks for a lost event;
- an all-ones write to the control register, which checks the reserved-bit mask.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int RegW   = 16;
  localparam int NumSrc = 8;

  // flag bit positions inside the interrupt register
  localparam int SrcJabber = 7;
  localparam int SrcRxErr  = 6;
  localparam int SrcLink   = 2;

  // control register: writable bits and polarity bit
  localparam logic [RegW-1:0] CtrlRwMask = 16'h6830;
  localparam int LevelBit = 14;

  // sources qualified by an edge of their raw input
  localparam logic [NumSrc-1:0] RiseMask = NumSrc'(1) << SrcRxErr;
  localparam logic [NumSrc-1:0] FallMask = NumSrc'(1) << SrcLink;

  typedef struct packed {
    logic selCtrl;
    logic selIrq;
    logic wrCtrl;
    logic wrIrq;
    logic clrIrq;
  } regStrobe_t;
endpackage

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int AddrW    = 5,
  parameter int CtrlAddr = 16,
  parameter int IrqAddr  = 17
) (
  input  logic [AddrW-1:0] regAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  output regStrobe_t       strb
);
  logic hitCtrl;
  logic hitIrq;

  assign hitCtrl = (regAddr == AddrW'(CtrlAddr));
  assign hitIrq  = (regAddr == AddrW'(IrqAddr));

  always_comb begin
    strb.selCtrl = hitCtrl;
    strb.selIrq  = hitIrq;
    strb.wrCtrl  = wrEn & hitCtrl;
    strb.wrIrq   = wrEn & hitIrq;
    strb.clrIrq  = rdEn & hitIrq;
  end
endmodule

// File: rtl/phy_irq_dp.sv
module phy_irq_dp
  import phy_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strb,
  input  logic [RegW-1:0]   wrData,
  input  logic [NumSrc-1:0] rawEv,
  output logic [RegW-1:0]   rdData,
  output logic [NumSrc-1:0] statusQ,
  output logic [NumSrc-1:0] enableQ,
  output logic              levelQ,
  output logic              irqPin
);
  logic [NumSrc-1:0] prevQ;
  logic [NumSrc-1:0] setVec;
  logic [RegW-1:0]   ctrlQ;
  logic              anyPending;

  for (genvar i = 0; i < NumSrc; i++) begin : g_src
    if (RiseMask[i]) begin : g_rise
      assign setVec[i] = rawEv[i] & ~prevQ[i];
    end else if (FallMask[i]) begin : g_fall
      assign setVec[i] = ~rawEv[i] & prevQ[i];
    end else begin : g_level
      assign setVec[i] = rawEv[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevQ   <= '0;
      statusQ <= '0;
      enableQ <= '0;
      ctrlQ   <= '0;
    end else begin
      prevQ   <= rawEv;
      statusQ <= (statusQ & ~{NumSrc{strb.clrIrq}}) | setVec;
      if (strb.wrIrq)  enableQ <= wrData[RegW-1:NumSrc];
      if (strb.wrCtrl) ctrlQ   <= wrData & CtrlRwMask;
    end
  end

  always_comb begin
    if (strb.selIrq)       rdData = {enableQ, statusQ};
    else if (strb.selCtrl) rdData = ctrlQ;
    else                   rdData = '0;
  end

  assign levelQ     = ctrlQ[LevelBit];
  assign anyPending = |(statusQ & enableQ);
  assign irqPin     = levelQ ? anyPending : ~anyPending;
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
#(
  parameter int AddrW    = 5,
  parameter int CtrlAddr = 16,
  parameter int IrqAddr  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AddrW-1:0] regAddr,
  input  logic [15:0]      wrData,
  input  logic             wrEn,
  input  logic             rdEn,
  output logic [15:0]      rdData,
  input  logic             evJabber,
  input  logic             evRxErr,
  input  logic             evPageRx,
  input  logic             evPdFault,
  input  logic             evLpAck,
  input  logic             evLinkOk,
  input  logic             evRemFault,
  input  logic             evAnegDone,
  output logic             irqPin
);
  regStrobe_t        strb;
  logic [NumSrc-1:0] rawEv;
  logic [NumSrc-1:0] statusQ;
  logic [NumSrc-1:0] enableQ;
  logic              levelQ;

  assign rawEv = {evJabber, evRxErr, evPageRx, evPdFault,
                  evLpAck, evLinkOk, evRemFault, evAnegDone};

  phy_irq_ctrl #(.AddrW(AddrW), .CtrlAddr(CtrlAddr), .IrqAddr(IrqAddr)) ctrl_i (
    .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  phy_irq_dp dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData), .rawEv(rawEv),
    .rdData(rdData), .statusQ(statusQ), .enableQ(enableQ), .levelQ(levelQ),
    .irqPin(irqPin)
  );
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int AddrW    = 5,
  parameter int CtrlAddr = 16,
  parameter int IrqAddr  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AddrW-1:0] regAddr,
  input logic             rdEn,
  input logic [15:0]      rdData,
  input logic [7:0]       rawEv,
  input logic [7:0]       status,
  input logic [7:0]       enable,
  input logic             level,
  input logic             irqPin
);
  logic clrRd;
  logic quiet;
  assign clrRd = rdEn && (regAddr == AddrW'(IrqAddr));
  // no source can fire: level sources low, receive error low, link held OK
  assign quiet = (rawEv == 8'b0000_0100);

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !clrRd |=> ((status & $past(status)) == $past(status))); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clrRd && quiet) |=> (status == 8'h00)); // R6
  AST_RXERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (clrRd && rawEv[6] && $past(rawEv[6])) |=> !status[6]); // R4
  AST_LINK_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clrRd && rawEv[2]) |=> !status[2]); // R5
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clrRd && rawEv[7]) |=> status[7]); // R7
  AST_PIN_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (level && (status & enable) != 8'h00) |-> irqPin); // R9
  AST_PIN_IDLE_LOW_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && (status & enable) == 8'h00) |-> irqPin); // R9
  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == AddrW'(CtrlAddr)) |-> ((rdData & 16'h97CF) == 16'h0000)); // R10
endmodule

bind phy_irq_unit phy_irq_chk #(.AddrW(AddrW), .CtrlAddr(CtrlAddr), .IrqAddr(IrqAddr)) chk_i (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .rdEn(rdEn), .rdData(rdData),
  .rawEv(rawEv), .status(statusQ), .enable(enableQ), .level(levelQ), .irqPin(irqPin)
);

// File: tb/phy_irq_unit_tb_top.sv
`timescale 1ns/1ps
module phy_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [7:0]  rawEv = '0;   // bit 7 jabber ... bit 2 link OK ... bit 0 negotiation done
  logic        irqPin;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phy_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData),
    .evJabber(rawEv[7]), .evRxErr(rawEv[6]), .evPageRx(rawEv[5]), .evPdFault(rawEv[4]),
    .evLpAck(rawEv[3]), .evLinkOk(rawEv[2]), .evRemFault(rawEv[1]), .evAnegDone(rawEv[0]),
    .irqPin(irqPin)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [15:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [15:0] v);
    regAddr = a; rdEn = 1'b1;
    #1 v = rdData;
    tick();
    rdEn = 1'b0;
  endtask

  // produce one qualifying event on source s
  task automatic fire(input int s);
    if (s == 2) begin
      rawEv[2] = 1'b1; tick();
      rawEv[2] = 1'b0; tick();
    end else begin
      rawEv[s] = 1'b1; tick();
      rawEv[s] = 1'b0; tick();
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 pin", {15'd0, irqPin}, 16'd1);
    rdReg(5'd17, v); chk("R1 irq reg", v, 16'h0000);
    rdReg(5'd16, v); chk("R1 ctrl reg", v, 16'h0000);

    // sweep: polarity x source, only a different source enabled first
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] en;
        logic [7:0] bitS;
        logic inact;
        en    = 8'h01 << ((s + 1) % 8);
        bitS  = 8'h01 << s;
        inact = (lvl == 0);
        wrReg(5'd16, lvl[0] ? 16'h4000 : 16'h0000);
        wrReg(5'd17, {en, 8'hFF});                       // R2 flag bits not writable
        chk("R2/R9 idle pin", {15'd0, irqPin}, {15'd0, inact});
        rdReg(5'd17, v); chk("R2 write ignored", v, {en, 8'h00});
        fire(s);
        chk("R8 masked pin", {15'd0, irqPin}, {15'd0, inact});
        wrReg(5'd17, {en | bitS, 8'h00});
        chk("R8/R9 pin active", {15'd0, irqPin}, {15'd0, ~inact});
        rdReg(5'd17, v);
        chk(s == 6 ? "R4 flag" : (s == 2 ? "R5 flag" : "R3 flag"), v, {en | bitS, bitS});
        chk("R6 pin after clear", {15'd0, irqPin}, {15'd0, inact});
        rdReg(5'd17, v); chk("R6 cleared", v, {en | bitS, 8'h00});
      end
    end
    wrReg(5'd16, 16'h0000);
    wrReg(5'd17, 16'h0000);

    // R4: held receive error latches once
    rawEv[6] = 1'b1; tick(); tick();
    rdReg(5'd17, v); chk("R4 first edge", v, 16'h0040);
    tick();
    rdReg(5'd17, v); chk("R4 held no reset", v, 16'h0000);
    rawEv[6] = 1'b0; tick();

    // R5: link rise sets nothing, drop sets bit 2
    rawEv[2] = 1'b1; tick(); tick();
    rdReg(5'd17, v); chk("R5 rise ignored", v, 16'h0000);
    rawEv[2] = 1'b0; tick();
    rdReg(5'd17, v); chk("R5 drop", v, 16'h0004);

    // R7: jabber in the same cycle as a clearing read
    rawEv[7] = 1'b1;
    rdReg(5'd17, v); chk("R7 pre-clear value", v, 16'h0000);
    rawEv[7] = 1'b0;
    rdReg(5'd17, v); chk("R7 flag kept", v, 16'h0080);

    // R10: control mask
    wrReg(5'd16, 16'hFFFF);
    rdReg(5'd16, v); chk("R10 rw bits", v, 16'h6830);
    chk("R10 pin high polarity idle", {15'd0, irqPin}, 16'd0);
    wrReg(5'd16, 16'h0000);
    rdReg(5'd16, v); chk("R10 cleared", v, 16'h0000);

    // R11: ctrl read keeps flags, other address reads 0
    fire(0);
    rdReg(5'd16, v); chk("R11 ctrl read", v, 16'h0000);
    rdReg(5'd5, v);  chk("R11 unmapped", v, 16'h0000);
    rdReg(5'd17, v); chk("R11 flag kept", v, 16'h0001);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule